// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Front-End

This block is a single-port synchronous SRAM with its own storage array. Reads and writes may alternate on every clock with no idle bus slot. Read data flows out of the array combinationally. It is valid in the clock cycle that follows the edge at which the read address was registered. Write data trails its address by one enabled edge (late write). A one-entry write buffer holds the most recent write until the next write replaces it. Reads that hit the buffered address get the buffered lanes merged in.

At each rising edge the control inputs are decoded into one command: stall (clock enable inactive), deselect, load-read, load-write or advance. A small state machine (DESELECTED, READING, WRITING) remembers which operation is in flight. An advance continues that operation at the next burst address, or keeps the block deselected. The two low address bits come from a burst counter. The counter runs in linear order or interleaved order, chosen by a static pin. The output enable is asynchronous and gates a tristate data output.

State transitions, all taken on an enabled edge: any state goes to DESELECTED on a deselect (named DESELECT), to READING on a load-read (BEGIN_READ) and to WRITING on a load-write (BEGIN_WRITE). An advance keeps the current state (CONTINUE, or CONTINUE_DESELECT when deselected). A stall keeps every register (IGNORE_EDGE).

Top module: `ztsram_front`

## Requirements
- R1: After reset the block is deselected and `q_drv` is low.
- R2: An edge with `cke_n` high changes no state: the inputs at that edge, including a write command, have no effect on the outputs or the array.
- R3: An enabled edge with `adv_ld_n` low and any select inactive deselects the block. A select is inactive when `sel1_n` is high, `sel2` is low or `sel3_n` is high. After such an edge `q_drv` stays low while `oe_n` is low.
- R4: An enabled edge with `adv_ld_n` low, all selects active and `we_n` high registers `addr`. Until the next enabled edge, `q` shows the word stored at that address.
- R5: An enabled edge with `adv_ld_n` low, all selects active and `we_n` low registers a write to `addr`. The word on `din` at the next enabled edge is the data written.
- R6: Byte lane i is bits [8i+7:8i]. It is written only if `bw_n[i]` was low at the write's address edge. A write with all `bw_n` high changes nothing.
- R7: `adv_ld_n` high at an enabled edge, while reading or writing, continues the same operation at the next burst address. The upper address bits stay fixed. The low two bits are start+n mod 4 when `order_ilv` is 0, and start XOR n when it is 1. A write advance takes its byte enables from that edge.
- R8: `adv_ld_n` high at an enabled edge while deselected leaves the block deselected.
- R9: `q_drv` is high, and `q` is driven, only while a read is in flight and `oe_n` is low. `oe_n` acts without waiting for a clock edge.
- R10: A read of an address whose write data is buffered but not yet in the array returns the buffered lanes merged with the stored lanes.
- R11: Any back-to-back sequence of reads and writes, with no idle cycles, returns on every read the data last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| adv_ld_n | input | 1 | Low: load new address/command; high: advance |
| we_n | input | 1 | Low: write, high: read (at load) |
| bw_n | input | DW/LANE | Per-lane active-low write enables |
| addr | input | log2(DEPTH) | Word address |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| din | input | DW | Write data, one enabled edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| q | output | DW | Read data, tristate (high-impedance when not driven) |
| q_drv | output | 1 | High when `q` is being driven |

## Verification
A wrong state register shows up one cycle after the faulty edge. Either `q_drv` is wrong, or `q` carries the word of another address. A wrong burst counter shows on the next advance as the word of the neighbouring address. A lost or misplaced write buffer is not visible at once. It shows on the first later read of that address, whether it is served by the bypass or by the array. So the scoreboard compares every cycle and revisits recently written addresses within a few cycles.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fsm_e;

    typedef enum logic [2:0] {
        CMD_STALL   = 3'd0,
        CMD_DESEL   = 3'd1,
        CMD_LOAD_RD = 3'd2,
        CMD_LOAD_WR = 3'd3,
        CMD_ADVANCE = 3'd4
    } cmd_e;

endpackage

// File: rtl/ztsram_decode.sv
module ztsram_decode
    import ztsram_pkg::*;
(
    input  logic cke_n,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    input  logic adv_ld_n,
    input  logic we_n,
    output cmd_e cmd
);

    logic chip_on;

    assign chip_on = !sel1_n && sel2 && !sel3_n;

    // Priority: stall beats advance beats select check.
    always_comb begin
        if (cke_n) begin
            cmd = CMD_STALL;
        end else if (adv_ld_n) begin
            cmd = CMD_ADVANCE;
        end else if (!chip_on) begin
            cmd = CMD_DESEL;
        end else if (we_n) begin
            cmd = CMD_LOAD_RD;
        end else begin
            cmd = CMD_LOAD_WR;
        end
    end

endmodule

// File: rtl/ztsram_burst.sv
module ztsram_burst #(
    parameter int AW = 6,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          order_ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);

    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (order_ilv) begin
            low_bits = base_q[BB-1:0] ^ cnt_q;
        end else begin
            low_bits = base_q[BB-1:0] + cnt_q;
        end
    end

    generate
        if (AW > BB) begin : g_hi
            assign addr_out = {base_q[AW-1:BB], low_bits};
        end else begin : g_lo
            assign addr_out = low_bits;
        end
    endgenerate

endmodule

// File: rtl/ztsram_array.sv
module ztsram_array #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int LANE  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = DW / LANE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_take,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pend_v,
    output logic [AW-1:0] pend_a,
    output logic [NB-1:0] pend_be,
    output logic [DW-1:0] pend_d
);

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    // Retire the buffered write when a new one replaces it.
    always_ff @(posedge clk) begin
        if (wr_take && pend_v) begin
            for (int i = 0; i < NB; i++) begin
                if (pend_be[i]) begin
                    mem[pend_a][i*LANE +: LANE] <= pend_d[i*LANE +: LANE];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v  <= 1'b0;
            pend_a  <= '0;
            pend_be <= '0;
            pend_d  <= '0;
        end else if (wr_take) begin
            pend_v  <= 1'b1;
            pend_a  <= wr_addr;
            pend_be <= wr_be;
            pend_d  <= wr_data;
        end
    end

    assign hit = pend_v && (pend_a == rd_addr);

    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign rd_data[g*LANE +: LANE] = (hit && pend_be[g])
                ? pend_d[g*LANE +: LANE]
                : mem[rd_addr][g*LANE +: LANE];
        end
    endgenerate

endmodule

// File: rtl/ztsram_front.sv
module ztsram_front
    import ztsram_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int DW         = 32,
    parameter int LANE       = 8,
    parameter int BURST_BITS = 2,
    localparam int AW        = $clog2(DEPTH),
    localparam int NB        = DW / LANE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          adv_ld_n,
    input  logic          we_n,
    input  logic [NB-1:0] bw_n,
    input  logic [AW-1:0] addr,
    input  logic          order_ilv,
    input  logic [DW-1:0] din,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          q_drv
);

    cmd_e          cmd;
    fsm_e          state_q;
    fsm_e          state_d;
    logic [NB-1:0] bw_q;
    logic          burst_load;
    logic          burst_step;
    logic          wr_take;
    logic          bw_grab;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] rd_data;
    logic          pend_v;
    logic [AW-1:0] pend_a;
    logic [NB-1:0] pend_be;
    logic [DW-1:0] pend_d;

    ztsram_decode u_decode (
        .cke_n    (cke_n),
        .sel1_n   (sel1_n),
        .sel2     (sel2),
        .sel3_n   (sel3_n),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .cmd      (cmd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: DESELECT, BEGIN_READ, BEGIN_WRITE, CONTINUE, IGNORE_EDGE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: begin
                if (cmd == CMD_LOAD_RD)      state_d = ST_READ;
                else if (cmd == CMD_LOAD_WR) state_d = ST_WRITE;
                else                         state_d = ST_DESEL;
            end
            ST_READ, ST_WRITE: begin
                if (cmd == CMD_LOAD_RD)      state_d = ST_READ;
                else if (cmd == CMD_LOAD_WR) state_d = ST_WRITE;
                else if (cmd == CMD_DESEL)   state_d = ST_DESEL;
                else                         state_d = state_q;
            end
            default: state_d = ST_DESEL;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        burst_load = 1'b0;
        burst_step = 1'b0;
        wr_take    = 1'b0;
        bw_grab    = 1'b0;
        unique case (state_q)
            ST_DESEL: begin
                burst_load = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
                bw_grab    = (cmd == CMD_LOAD_WR);
            end
            ST_READ: begin
                burst_load = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
                burst_step = (cmd == CMD_ADVANCE);
                bw_grab    = (cmd == CMD_LOAD_WR);
            end
            ST_WRITE: begin
                burst_load = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
                burst_step = (cmd == CMD_ADVANCE);
                bw_grab    = (cmd == CMD_LOAD_WR) || (cmd == CMD_ADVANCE);
                wr_take    = (cmd != CMD_STALL);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bw_q <= '1;
        end else if (bw_grab) begin
            bw_q <= bw_n;
        end
    end

    ztsram_burst #(
        .AW (AW),
        .BB (BURST_BITS)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (burst_load),
        .step      (burst_step),
        .order_ilv (order_ilv),
        .addr_in   (addr),
        .addr_out  (cur_addr)
    );

    ztsram_array #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .LANE  (LANE)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_take (wr_take),
        .wr_addr (cur_addr),
        .wr_be   (~bw_q),
        .wr_data (din),
        .rd_addr (cur_addr),
        .rd_data (rd_data),
        .pend_v  (pend_v),
        .pend_a  (pend_a),
        .pend_be (pend_be),
        .pend_d  (pend_d)
    );

    assign q_drv = (state_q == ST_READ) && !oe_n;
    assign q     = q_drv ? rd_data : {DW{1'bz}};

endmodule

// File: rtl/ztsram_front_chk.sv
module ztsram_front_chk
    import ztsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32,
    parameter int BB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          sel1_n,
    input logic          sel2,
    input logic          sel3_n,
    input logic          adv_ld_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] din,
    input logic          q_drv,
    input fsm_e          state_q,
    input logic [AW-1:0] cur_addr,
    input logic          pend_v,
    input logic [AW-1:0] pend_a,
    input logic [DW-1:0] pend_d
);

    logic all_sel;
    assign all_sel = !sel1_n && sel2 && !sel3_n;

    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_q == ST_DESEL));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(state_q) && $stable(cur_addr) && $stable(pend_v)
                   && $stable(pend_a) && $stable(pend_d)));

    p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld_n && !all_sel) |=> (state_q == ST_DESEL));

    p_load_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld_n && all_sel && we_n)
        |=> (state_q == ST_READ && cur_addr == $past(addr)));

    p_late_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && state_q == ST_WRITE)
        |=> (pend_v && pend_a == $past(cur_addr) && pend_d == $past(din)));

    p_burst_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld_n && state_q != ST_DESEL)
        |=> (state_q == $past(state_q)
             && cur_addr[AW-1:BB] == $past(cur_addr[AW-1:BB])));

    p_cont_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld_n && state_q == ST_DESEL) |=> (state_q == ST_DESEL));

    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drv);

endmodule

bind ztsram_front ztsram_front_chk #(
    .AW (AW),
    .DW (DW),
    .BB (BURST_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .adv_ld_n (adv_ld_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .din      (din),
    .q_drv    (q_drv),
    .state_q  (state_q),
    .cur_addr (cur_addr),
    .pend_v   (pend_v),
    .pend_a   (pend_a),
    .pend_d   (pend_d)
);

// File: tb/ztsram_front_bench.sv
`timescale 1ns/100ps
module ztsram_front_bench;

    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int NB    = 4;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          adv_ld_n = 1'b0;
    logic          we_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          order_ilv = 1'b0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    wire  [DW-1:0] q;
    wire           q_drv;

    ztsram_front u_ztsram_front (
        .clk (clk), .rst_n (rst_n), .cke_n (cke_n), .sel1_n (sel1_n),
        .sel2 (sel2), .sel3_n (sel3_n), .adv_ld_n (adv_ld_n), .we_n (we_n),
        .bw_n (bw_n), .addr (addr), .order_ilv (order_ilv), .din (din),
        .oe_n (oe_n), .q (q), .q_drv (q_drv)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          drv;
        logic [DW-1:0] data;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Reference model state: 0 deselected, 1 reading, 2 writing
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_st = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [NB-1:0] m_bw = '1;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = order_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic fail_line(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // Driver: one bus cycle, model update, expectation push
    task automatic cyc(bit stall, bit sel_ok, bit adv, bit we,
                       logic [NB-1:0] bw, logic [AW-1:0] a, bit oe, string tag);
        item_t it;
        @(negedge clk);
        cke_n = stall; adv_ld_n = adv; we_n = we; bw_n = bw; addr = a;
        din = $urandom; oe_n = oe;
        if (sel_ok) begin
            sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        end else begin
            sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
            case ($urandom_range(0, 2))
                0: sel1_n = 1'b1;
                1: sel2   = 1'b0;
                default: sel3_n = 1'b1;
            endcase
        end
        if (!stall) begin
            if (m_st == 2) begin
                for (int i = 0; i < NB; i++)
                    if (!m_bw[i]) ref_mem[m_addr()][i*8 +: 8] = din[i*8 +: 8];
            end
            if (adv) begin
                if (m_st != 0) begin
                    m_cnt = m_cnt + 1'b1;
                    if (m_st == 2) m_bw = bw;
                end
            end else if (!sel_ok) begin
                m_st = 0;
            end else begin
                m_base = a; m_cnt = '0;
                m_st = we ? 1 : 2;
                if (!we) m_bw = bw;
            end
        end
        it.drv  = (m_st == 1) && !oe;
        it.data = ref_mem[m_addr()];
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        cyc(0, 1, 0, 1, '1, a, 0, tag);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NB-1:0] bw, string tag);
        cyc(0, 1, 0, 0, bw, a, 0, tag);
    endtask

    // Monitor: pop one expectation per edge and compare
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (q_drv !== e.drv) fail_line(e.tag, "q_drv", {31'b0, q_drv}, {31'b0, e.drv});
                else if (e.drv && q !== e.data) fail_line(e.tag, "q", q, e.data);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (q_drv !== 1'b0) fail_line("R1", "q_drv after reset", {31'b0, q_drv}, '0);

        // Fill every word, back to back (R5)
        for (int a = 0; a < DEPTH; a++) wr(a[AW-1:0], 4'h0, "R5");
        // Read all back, reads directly after writes (R4, R11)
        for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0], "R4");

        // Partial lanes, then bypass read of the buffered word (R6, R10)
        wr(6'd5, 4'b1010, "R6");
        rd(6'd5, "R10");
        wr(6'd7, 4'b0011, "R10");
        cyc(0, 1, 0, 1, '1, 6'd7, 0, "R10");
        wr(6'd20, 4'h0, "R6");
        wr(6'd21, 4'h0, "R6");
        rd(6'd5, "R6");
        rd(6'd7, "R6");
        // Write abort (R6)
        wr(6'd9, 4'hF, "R6");
        rd(6'd9, "R6");
        wr(6'd22, 4'h0, "R6");
        rd(6'd9, "R6");

        // Linear burst read from start 2, wraps inside the group (R7)
        order_ilv = 1'b0;
        rd(6'd14, "R7");
        for (int k = 0; k < 5; k++) cyc(0, 1, 1, 1, '1, 6'd0, 0, "R7");
        // Interleaved burst write then burst read (R7)
        cyc(0, 0, 0, 1, '1, 6'd0, 0, "R3");
        order_ilv = 1'b1;
        wr(6'd33, 4'h0, "R7");
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 0, 4'h0, 6'd0, 0, "R7");
        rd(6'd33, "R7");
        for (int k = 0; k < 4; k++) cyc(0, 1, 1, 1, '1, 6'd0, 0, "R7");

        // Deselect then continue-deselect (R3, R8)
        cyc(0, 0, 0, 1, '1, 6'd1, 0, "R3");
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, '1, 6'd2, 0, "R8");

        // Stall ignores a write command (R2)
        rd(6'd40, "R4");
        cyc(1, 1, 0, 0, 4'h0, 6'd41, 0, "R2");
        cyc(1, 0, 0, 1, '1, 6'd42, 0, "R2");
        rd(6'd41, "R2");
        rd(6'd40, "R2");

        // Output enable acts between edges (R9)
        rd(6'd12, "R9");
        @(posedge clk);
        #3 oe_n = 1'b1;
        #1 n_chk++;
        if (q_drv !== 1'b0) fail_line("R9", "q_drv with oe_n high", {31'b0, q_drv}, '0);
        oe_n = 1'b0;
        #0.5 n_chk++;
        if (q_drv !== 1'b1) fail_line("R9", "q_drv with oe_n low", {31'b0, q_drv}, 32'd1);
        cyc(0, 1, 1, 1, '1, 6'd0, 1, "R9");
        cyc(0, 1, 1, 1, '1, 6'd0, 0, "R9");

        // Random mix, no idle cycles (R11)
        for (int phase = 0; phase < 2; phase++) begin
            cyc(0, 0, 0, 1, '1, 6'd0, 0, "R3");
            order_ilv = phase[0];
            for (int n = 0; n < 3000; n++) begin
                int r;
                logic [NB-1:0] bw;
                logic [AW-1:0] a;
                r  = $urandom_range(0, 99);
                bw = $urandom;
                if ($urandom_range(0, 4) == 0) bw = '1;
                else if ($urandom_range(0, 3) == 0) bw = '0;
                a  = (m_st != 0 && $urandom_range(0, 1) == 1) ? m_addr() : $urandom;
                if (r < 30)      cyc(0, 1, 0, 1, '1, a, ($urandom_range(0, 9) == 0), "R11");
                else if (r < 60) cyc(0, 1, 0, 0, bw, a, 0, "R11");
                else if (r < 82) cyc(0, 1, 1, ($urandom_range(0, 1) == 1), bw, a, 0, "R7");
                else if (r < 90) cyc(0, 0, 0, 1, '1, a, 0, "R3");
                else             cyc(1, ($urandom_range(0, 1) == 1), 0, 0, bw, a, 0, "R2");
            end
        end

        @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule